// File: doc/BRIEF.md
# Strap-Selected Reference Clock Divider

This block divides a reference clock by one of nine integer ratios and emits a comparison pulse at the divided rate for a phase detector. Two strap inputs choose the ratio. Each strap has three levels: tied low, left floating or tied high. The levels reach the block already sensed as 2-bit codes. The available ratios are 32, 33, 35, 36, 48, 49, 63, 64 and 65. Each one brings a matching crystal frequency down to 512 kHz.

A plus-one control raises the selected ratio by one while the divider runs. This moves the harmonics of the comparison rate away from a sensitive band. A change of strap or plus-one setting is only picked up at the end of a division cycle, so a cycle is never cut short. A second output gives a square-ish copy of the divided rate for a test pin.

Top module: `ref_strap_divider`

## Requirements
- R1: While `rst` is high at a clock edge, both `cmp_pulse` and `mon_out` are low after that edge.
- R2: After `rst` falls, the first `cmp_pulse` is high in the cycle after the N-th rising edge, where N is the ratio selected during reset.
- R3: `cmp_pulse` is high for exactly one clock cycle, and successive pulses are N cycles apart.
- R4: Strap codes are 00 = low, 01 = floating, 10 = high. The pair (first, second) selects the ratio as follows:
  - low/low → 48, low/floating → 36, low/high → 33
  - floating/low → 64, floating/floating → 65, floating/high → 63
  - high/low → 49, high/floating → 35, high/high → 32
- R5: Strap code 11 selects the same ratio as code 01 (floating).
- R6: With `plus_one` high, the ratio is the strap ratio plus one.
- R7: A change on `strap_a`, `strap_b` or `plus_one` during a division cycle does not alter the length of that cycle. The new ratio applies from the next cycle on, including a change made in the last cycle before the terminal count.
- R8: `mon_out` is low in the cycle where `cmp_pulse` is high. Within each division cycle of N clocks it is high for N − floor(N/2) cycles, in a single run that ends at the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_a | input | 2 | First strap level code |
| strap_b | input | 2 | Second strap level code |
| plus_one | input | 1 | Add one to the strap-selected ratio |
| cmp_pulse | output | 1 | One-cycle pulse at the divided rate |
| mon_out | output | 1 | Divided-rate square wave for the test pin |

## Verification
The risky coincidence is a ratio change that arrives in the same cycle as the terminal count. A design that latches the new ratio one cycle too late, or that reloads the counter mid-cycle, goes wrong only there. The bench counts clocks from a pulse and then changes the straps exactly N−1 clocks later, so the update edge is also the wrap edge. It then requires the ongoing cycle to keep its old length and the following cycle to take the new one. A second change in mid-cycle checks that the current cycle is not truncated.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;

    localparam int unsigned RATIO_W = 7;

    typedef enum logic [1:0] {
        STRAP_LOW   = 2'b00,
        STRAP_FLOAT = 2'b01,
        STRAP_HIGH  = 2'b10,
        STRAP_SPARE = 2'b11
    } strap_t;

    typedef struct packed {
        logic [RATIO_W-1:0] count;
        logic [RATIO_W-1:0] ratio;
    } div_state_t;

    // Code 11 folds onto the floating level.
    function automatic strap_t strap_fold(input logic [1:0] code);
        strap_t s;
        s = strap_t'(code);
        if (s == STRAP_SPARE) s = STRAP_FLOAT;
        return s;
    endfunction

    function automatic logic [RATIO_W-1:0] strap_ratio(input strap_t a, input strap_t b);
        logic [RATIO_W-1:0] r;
        unique case (a)
            STRAP_LOW:  r = (b == STRAP_LOW) ? RATIO_W'(48) :
                            (b == STRAP_HIGH) ? RATIO_W'(33) : RATIO_W'(36);
            STRAP_HIGH: r = (b == STRAP_LOW) ? RATIO_W'(49) :
                            (b == STRAP_HIGH) ? RATIO_W'(32) : RATIO_W'(35);
            default:    r = (b == STRAP_LOW) ? RATIO_W'(64) :
                            (b == STRAP_HIGH) ? RATIO_W'(63) : RATIO_W'(65);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ref_ratio_sel.sv
module ref_ratio_sel
    import ref_div_pkg::*;
#(
    parameter int unsigned W = RATIO_W
) (
    input  logic [1:0]   strap_a,
    input  logic [1:0]   strap_b,
    input  logic         plus_one,
    output logic [W-1:0] ratio
);
    logic [RATIO_W-1:0] base;

    always_comb begin
        base  = strap_ratio(strap_fold(strap_a), strap_fold(strap_b));
        ratio = W'(base) + W'(plus_one);
    end
endmodule

// File: rtl/ref_div_core.sv
module ref_div_core
    import ref_div_pkg::*;
#(
    parameter int unsigned W = RATIO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] ratio_in,
    output logic [W-1:0] count_q,
    output logic [W-1:0] ratio_q,
    output logic [W-1:0] count_nxt,
    output logic [W-1:0] ratio_nxt,
    output logic         pulse_q
);
    logic [W-1:0] cnt_r, n_r;
    logic [W-1:0] cnt_d, n_d;
    logic         wrap;

    always_comb begin
        wrap = (cnt_r == n_r - W'(1));
        if (rst || wrap) begin
            cnt_d = '0;
            n_d   = ratio_in;
        end else begin
            cnt_d = cnt_r + W'(1);
            n_d   = n_r;
        end
    end

    always_ff @(posedge clk) begin
        cnt_r   <= cnt_d;
        n_r     <= n_d;
        pulse_q <= !rst && wrap;
    end

    assign count_q   = cnt_r;
    assign ratio_q   = n_r;
    assign count_nxt = cnt_d;
    assign ratio_nxt = n_d;
endmodule

// File: rtl/ref_div_monitor.sv
module ref_div_monitor #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] count_nxt,
    input  logic [W-1:0] ratio_nxt,
    output logic         mon_q
);
    always_ff @(posedge clk) begin
        if (rst) mon_q <= 1'b0;
        else     mon_q <= (count_nxt >= (ratio_nxt >> 1));
    end
endmodule

// File: rtl/ref_strap_divider.sv
module ref_strap_divider
    import ref_div_pkg::*;
#(
    parameter int unsigned W = RATIO_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] strap_a,
    input  logic [1:0] strap_b,
    input  logic       plus_one,
    output logic       cmp_pulse,
    output logic       mon_out
);
    logic [W-1:0] sel_ratio;
    logic [W-1:0] cnt_q, n_cur, cnt_nx, n_nx;

    ref_ratio_sel #(.W(W)) u_sel (
        .strap_a  (strap_a),
        .strap_b  (strap_b),
        .plus_one (plus_one),
        .ratio    (sel_ratio)
    );

    ref_div_core #(.W(W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .ratio_in  (sel_ratio),
        .count_q   (cnt_q),
        .ratio_q   (n_cur),
        .count_nxt (cnt_nx),
        .ratio_nxt (n_nx),
        .pulse_q   (cmp_pulse)
    );

    ref_div_monitor #(.W(W)) u_mon (
        .clk       (clk),
        .rst       (rst),
        .count_nxt (cnt_nx),
        .ratio_nxt (n_nx),
        .mon_q     (mon_out)
    );
endmodule

// File: rtl/ref_div_checker.sv
module ref_div_checker #(
    parameter int unsigned W = 7
) (
    input logic         clk,
    input logic         rst,
    input logic         cmp_pulse,
    input logic         mon_out,
    input logic [W-1:0] n_cur,
    input logic [W-1:0] cnt_q
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!cmp_pulse && !mon_out));

    p_one_wide_r3: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |=> !cmp_pulse);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
        cnt_q < n_cur);

    p_ratio_legal_r4: assert property (@(posedge clk) disable iff (rst)
        (n_cur >= W'(32)) && (n_cur <= W'(66)));

    p_hold_ratio_r7: assert property (@(posedge clk) disable iff (rst)
        (!cmp_pulse && !$past(rst)) |-> $stable(n_cur));

    p_mon_low_at_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |-> !mon_out);

    p_mon_fall_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(mon_out) |-> cmp_pulse);
endmodule

bind ref_strap_divider ref_div_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmp_pulse (cmp_pulse),
    .mon_out   (mon_out),
    .n_cur     (n_cur),
    .cnt_q     (cnt_q)
);

// File: tb/ref_strap_divider_test.sv
module ref_strap_divider_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] strap_a = 2'b00;
    logic [1:0] strap_b = 2'b00;
    logic       plus_one = 1'b0;
    logic       cmp_pulse, mon_out;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    ref_strap_divider uut (
        .clk(clk), .rst(rst), .strap_a(strap_a), .strap_b(strap_b),
        .plus_one(plus_one), .cmp_pulse(cmp_pulse), .mon_out(mon_out)
    );

    // Ratio from the requirement table (R4, R5, R6).
    function automatic int expect_ratio(input logic [1:0] a, input logic [1:0] b, input logic p);
        int ia, ib, r;
        ia = (a == 2'b11) ? 1 : int'(a);
        ib = (b == 2'b11) ? 1 : int'(b);
        case (ia * 3 + ib)
            0: r = 48;  1: r = 36;  2: r = 33;
            3: r = 64;  4: r = 65;  5: r = 63;
            6: r = 49;  7: r = 35;  default: r = 32;
        endcase
        return r + int'(p);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start(input logic [1:0] a, input logic [1:0] b, input logic p);
        @(negedge clk);
        rst = 1'b1; strap_a = a; strap_b = b; plus_one = p;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 pulse in reset", int'(cmp_pulse), 0);
            check("R1 monitor in reset", int'(mon_out), 0);
        end
        rst = 1'b0;
    endtask

    task automatic wait_first(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cmp_pulse && n < 300);
    endtask

    // Starts at a pulse cycle; optional input change after chg_at clocks.
    task automatic period(input int chg_at, input logic [1:0] na, input logic [1:0] nb,
                          input logic np, output int len, output int hi);
        len = 0; hi = 0;
        forever begin
            @(negedge clk);
            len++;
            if (len == chg_at) begin
                strap_a = na; strap_b = nb; plus_one = np;
            end
            if (cmp_pulse || len >= 300) break;
            if (mon_out) hi++;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int n, len, hi, e1, e2, e3;
        string tag;
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                for (int p = 0; p < 2; p++) begin
                    n = expect_ratio(2'(a), 2'(b), 1'(p));
                    tag = (p == 1) ? "R6" : ((a == 3 || b == 3) ? "R5" : "R4");
                    start(2'(a), 2'(b), 1'(p));
                    wait_first(len);
                    check($sformatf("R2 %s first pulse a=%0d b=%0d p=%0d", tag, a, b, p), len, n);
                    check("R8 monitor low at pulse", int'(mon_out), 0);
                    period(0, 2'b00, 2'b00, 1'b0, len, hi);
                    check($sformatf("R3 %s period a=%0d b=%0d p=%0d", tag, a, b, p), len, n);
                    check("R8 monitor high count", hi, n - n / 2);
                    period(0, 2'b00, 2'b00, 1'b0, len, hi);
                    check("R3 repeat period", len, n);
                end
            end
        end

        // R7: mid-cycle change, then a change in the last cycle before wrap.
        e1 = expect_ratio(2'b10, 2'b10, 1'b0);
        e2 = expect_ratio(2'b10, 2'b10, 1'b1);
        e3 = expect_ratio(2'b00, 2'b00, 1'b1);
        start(2'b10, 2'b10, 1'b0);
        wait_first(len);
        check("R2 first pulse before change", len, e1);
        period(10, 2'b10, 2'b10, 1'b1, len, hi);
        check("R7 mid-cycle change keeps length", len, e1);
        period(e2 - 1, 2'b00, 2'b00, 1'b1, len, hi);
        check("R7 change at terminal cycle keeps length", len, e2);
        period(0, 2'b00, 2'b00, 1'b0, len, hi);
        check("R7 new ratio after terminal count", len, e3);
        check("R8 monitor after change", hi, e3 - e3 / 2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule